// File: doc/BRIEF.md
# PRBS Pattern Checker with Error Counters

This block sits on the receive side of a serial link, after deserialization. It compares each parallel data word against a chosen test pattern and keeps two running totals: the number of bits compared and the number of those bits that were wrong. A bit error rate is the ratio of the two totals. The division is left to whoever reads the counters.

The checker needs no seed shared with the transmitter. For the pseudo-random patterns it predicts each bit from bits it has already received. It then loads its own generator from that history and runs the generator on its own once lock is declared. For the two fixed toggle patterns it tests every bit rotation of the pattern against the incoming word and adopts the rotation that matches.

Checking runs between a start pulse and a stop pulse. A synchronous reset clears the test. Lock is reported on an output, and a sticky flag shows when a counter has reached its ceiling.

Top module: `prbs_ber_monitor`

## Requirements
- R1: While `srst` is high, and in the cycle after it, `locked`, `bits_tested`, `error_bits` and `count_saturated` are all zero and checking is idle.
- R2: A `start` pulse begins checking from the next cycle. A `stop` pulse ends it and wins if both are high. A word presented in the same cycle as `stop` is not counted, and `locked` is low after that edge.
- R3: With `pat_sel` 0, 1, 2 or 3 the sequence is PRBS7 (x^7+x^6+1), PRBS15 (x^15+x^14+1), PRBS23 (x^23+x^18+1) or PRBS31 (x^31+x^28+1). Each is uninverted, with `rx_data` bit 0 the earliest bit in time. `locked` rises at the edge of the 32nd consecutive valid word that matches the prediction while checking is active.
- R4: In PRBS modes, an all-zero word never counts toward lock and breaks the run of matching words.
- R5: With `pat_sel` 4 the pattern is alternating 1,0,1,0. With `pat_sel` 5 it is five ones then five zeros. Either one locks after 32 consecutive matching words, whatever its bit rotation.
- R6: `bits_tested` grows by the word width for each valid word accepted while checking is active and `locked` is high. It does not change on cycles without `rx_valid`.
- R7: `error_bits` grows by the number of bit positions where the word differs from the expected word. After lock the expected word comes from the checker's own free-running generator or phase, so isolated bit errors are counted and do not cost lock.
- R8: While locked, four consecutive valid words that each have more than half their bits wrong drop `locked` at the edge of the fourth word. Three such words do not. Words counted while locked include the failing ones.
- R9: After lock is lost the checker reloads from the received stream. A clean stream relocks after 32 matching words.
- R10: Both counters stop at all ones and never wrap. `count_saturated` rises at the edge where either counter reaches all ones, and stays high until reset.
- R11: While checking is stopped the counters hold their values. A new `start` does not clear them; only `srst` does.
- R12: `pat_sel` values 6 and 7 never produce lock, so nothing is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high; clears the test |
| start | input | 1 | Pulse to begin checking |
| stop | input | 1 | Pulse to end checking; wins over start |
| pat_sel | input | 3 | Pattern code: 0..3 PRBS7/15/23/31, 4 alternating, 5 five-run toggle |
| rx_data | input | W | Received word, bit 0 earliest |
| rx_valid | input | 1 | Qualifies rx_data |
| locked | output | 1 | Checker is aligned to the stream |
| bits_tested | output | CNT_W | Bits compared since reset |
| error_bits | output | CNT_W | Mismatching bits since reset |
| count_saturated | output | 1 | Sticky: a counter reached all ones |

## Verification
Each of the four PRBS polynomials is driven from a random nonzero seed, so a wrong tap or a wrong bit order shows up as a failure to lock. The two toggle patterns start at random rotations, which separates a true rotation search from a match that only works at one phase. A run of all-zero words tells the zero guard apart from a plain predictor that would lock on it. Fully inverted words, in runs of three and then four, mark the exact loss threshold. Sparse random bit flips show that the post-lock generator runs free instead of being resynchronized, and a long clean stream with a narrow counter drives both counters into saturation.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   localparam int HIST_W = 31;
   localparam int NCAND  = 10;

   typedef enum logic [2:0] {
      PAT_P7   = 3'd0,
      PAT_P15  = 3'd1,
      PAT_P23  = 3'd2,
      PAT_P31  = 3'd3,
      PAT_ALT  = 3'd4,
      PAT_RUN5 = 3'd5
   } pat_e;

   function automatic int long_tap(input logic [2:0] s);
      case (s)
         3'd0:    return 7;
         3'd1:    return 15;
         3'd2:    return 23;
         default: return 31;
      endcase
   endfunction

   function automatic int short_tap(input logic [2:0] s);
      case (s)
         3'd0:    return 6;
         3'd1:    return 14;
         3'd2:    return 18;
         default: return 28;
      endcase
   endfunction

   function automatic logic is_prbs(input logic [2:0] s);
      return (s[2] == 1'b0);
   endfunction

   function automatic logic is_toggle(input logic [2:0] s);
      return (s == PAT_ALT) || (s == PAT_RUN5);
   endfunction

   function automatic int toggle_period(input logic [2:0] s);
      return (s == PAT_ALT) ? 2 : 10;
   endfunction

   function automatic logic toggle_bit(input logic [2:0] s, input int pos);
      if (s == PAT_ALT) return ((pos % 2) == 0);
      return ((pos % 10) < 5);
   endfunction

endpackage

// File: rtl/prbs_predict.sv
module prbs_predict
   import prbs_chk_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [2:0]        sel_i,
   input  logic              self_i,
   input  logic [W-1:0]      rx_i,
   input  logic [HIST_W-1:0] hist_i,
   output logic [W-1:0]      exp_o,
   output logic [HIST_W-1:0] hist_o
);

   logic [W-1:0] src_w;

   always_comb begin
      logic [W-1:0] e_v;
      logic         a;
      logic         b;
      int           lt;
      int           st;
      lt  = long_tap(sel_i);
      st  = short_tap(sel_i);
      e_v = '0;
      for (int i = 0; i < W; i++) begin
         if (lt <= i) a = self_i ? rx_i[i-lt] : e_v[i-lt];
         else         a = hist_i[lt-i-1];
         if (st <= i) b = self_i ? rx_i[i-st] : e_v[i-st];
         else         b = hist_i[st-i-1];
         e_v[i] = a ^ b;
      end
      exp_o = e_v;
   end

   assign src_w = self_i ? rx_i : exp_o;

   for (genvar k = 0; k < HIST_W; k++) begin : g_hist
      if (k < W) begin : g_from_word
         assign hist_o[k] = src_w[W-1-k];
      end else begin : g_from_old
         assign hist_o[k] = hist_i[k-W];
      end
   end

endmodule

// File: rtl/toggle_phase.sv
module toggle_phase
   import prbs_chk_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [2:0]   sel_i,
   input  logic [W-1:0] rx_i,
   input  logic [3:0]   phase_i,
   output logic [W-1:0] exp_o,
   output logic         found_o,
   output logic [3:0]   adv_cur_o,
   output logic [3:0]   adv_hit_o
);

   logic [NCAND-1:0][W-1:0] cand;
   logic [NCAND-1:0]        match;
   logic [3:0]              hit;

   function automatic logic [3:0] advance(input logic [3:0] p, input logic [2:0] s);
      int per;
      per = toggle_period(s);
      return 4'((int'(p) + (W % per)) % per);
   endfunction

   always_comb begin
      for (int c = 0; c < NCAND; c++) begin
         for (int i = 0; i < W; i++) cand[c][i] = toggle_bit(sel_i, c + i);
         match[c] = (rx_i == cand[c]) && (c < toggle_period(sel_i));
      end
   end

   always_comb begin
      found_o = 1'b0;
      hit     = '0;
      for (int c = NCAND - 1; c >= 0; c--) begin
         if (match[c]) begin
            found_o = 1'b1;
            hit     = 4'(c);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < W; i++) exp_o[i] = toggle_bit(sel_i, int'(phase_i) + i);
   end

   assign adv_cur_o = advance(phase_i, sel_i);
   assign adv_hit_o = advance(hit, sel_i);

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
   parameter int LOCK_WORDS = 32,
   parameter int LOSS_WORDS = 4
) (
   input  logic clk,
   input  logic srst_i,
   input  logic active_i,
   input  logic valid_i,
   input  logic clean_i,
   input  logic bad_i,
   output logic lock_o
);

   localparam int CW = $clog2(LOCK_WORDS + 1);
   localparam int LW = $clog2(LOSS_WORDS + 1);

   logic [CW-1:0] clean_q;
   logic [LW-1:0] bad_q;

   always_ff @(posedge clk) begin
      if (srst_i || !active_i) begin
         lock_o  <= 1'b0;
         clean_q <= '0;
         bad_q   <= '0;
      end else if (valid_i) begin
         if (!lock_o) begin
            bad_q <= '0;
            if (clean_i) begin
               if (clean_q == CW'(LOCK_WORDS - 1)) begin
                  lock_o  <= 1'b1;
                  clean_q <= '0;
               end else begin
                  clean_q <= clean_q + 1'b1;
               end
            end else begin
               clean_q <= '0;
            end
         end else begin
            clean_q <= '0;
            if (bad_i) begin
               if (bad_q == LW'(LOSS_WORDS - 1)) begin
                  lock_o <= 1'b0;
                  bad_q  <= '0;
               end else begin
                  bad_q <= bad_q + 1'b1;
               end
            end else begin
               bad_q <= '0;
            end
         end
      end
   end

   AST_LOCK_AFTER_CLEAN: assert property (@(posedge clk) disable iff (srst_i)
      $rose(lock_o) |-> $past(valid_i && clean_i && active_i)); // R3
   AST_DROP_WHEN_IDLE: assert property (@(posedge clk) disable iff (srst_i)
      !active_i |=> !lock_o); // R2
   AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (srst_i)
      $fell(lock_o) |-> $past(!active_i || (valid_i && bad_i))); // R8

endmodule

// File: rtl/ber_accum.sv
module ber_accum #(
   parameter int CNT_W = 48,
   parameter int INC_W = 6
) (
   input  logic             clk,
   input  logic             srst_i,
   input  logic             en_i,
   input  logic [INC_W-1:0] inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_o
);

   localparam logic [CNT_W:0] TOP = {1'b0, {CNT_W{1'b1}}};

   logic [CNT_W:0] sum;

   assign sum   = {1'b0, cnt_o} + (CNT_W + 1)'(inc_i);
   assign hit_o = en_i && (sum >= TOP);

   always_ff @(posedge clk) begin
      if (srst_i)         cnt_o <= '0;
      else if (hit_o)     cnt_o <= TOP[CNT_W-1:0];
      else if (en_i)      cnt_o <= sum[CNT_W-1:0];
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (srst_i)
      en_i |=> (cnt_o >= $past(cnt_o))); // R10
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (srst_i)
      !en_i |=> $stable(cnt_o)); // R11

endmodule

// File: rtl/prbs_ber_monitor.sv
module prbs_ber_monitor
   import prbs_chk_pkg::*;
#(
   parameter int W          = 32,
   parameter int CNT_W      = 48,
   parameter int LOCK_WORDS = 32,
   parameter int LOSS_WORDS = 4
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             start,
   input  logic             stop,
   input  logic [2:0]       pat_sel,
   input  logic [W-1:0]     rx_data,
   input  logic             rx_valid,
   output logic             locked,
   output logic [CNT_W-1:0] bits_tested,
   output logic [CNT_W-1:0] error_bits,
   output logic             count_saturated
);

   localparam int POP_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] CMAX = '1;

   if (W < 8) begin : g_bad_w
      $error("W must be at least 8");
   end
   if (LOCK_WORDS < 2 || LOSS_WORDS < 1) begin : g_bad_win
      $error("lock and loss windows too small");
   end
   if (CNT_W <= POP_W) begin : g_bad_cnt
      $error("CNT_W must exceed the per-word increment width");
   end

   logic              run_q;
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_nxt;
   logic [3:0]        phase_q;
   logic [W-1:0]      exp_prbs;
   logic [W-1:0]      exp_tog;
   logic [W-1:0]      exp_word;
   logic [W-1:0]      diff;
   logic [POP_W-1:0]  pop;
   logic              tog_found;
   logic [3:0]        adv_cur;
   logic [3:0]        adv_hit;
   logic              active;
   logic              clean;
   logic              bad;
   logic              cnt_en;
   logic              hit_b;
   logic              hit_e;

   assign active = run_q && !stop;

   always_ff @(posedge clk) begin
      if (srst || stop) run_q <= 1'b0;
      else if (start)   run_q <= 1'b1;
   end

   prbs_predict #(.W(W)) u_pred (
      .sel_i  (pat_sel),
      .self_i (!locked),
      .rx_i   (rx_data),
      .hist_i (hist_q),
      .exp_o  (exp_prbs),
      .hist_o (hist_nxt)
   );

   toggle_phase #(.W(W)) u_tog (
      .sel_i     (pat_sel),
      .rx_i      (rx_data),
      .phase_i   (phase_q),
      .exp_o     (exp_tog),
      .found_o   (tog_found),
      .adv_cur_o (adv_cur),
      .adv_hit_o (adv_hit)
   );

   assign exp_word = is_prbs(pat_sel) ? exp_prbs : exp_tog;
   assign diff     = rx_data ^ exp_word;

   always_comb begin
      pop = '0;
      for (int i = 0; i < W; i++) pop = pop + POP_W'(diff[i]);
   end

   always_comb begin
      if (is_prbs(pat_sel))        clean = (pop == '0) && (rx_data != '0);
      else if (is_toggle(pat_sel)) clean = tog_found;
      else                         clean = 1'b0;
   end

   assign bad = (int'(pop) > (W / 2));

   always_ff @(posedge clk) begin
      if (srst) begin
         hist_q  <= '0;
         phase_q <= '0;
      end else if (rx_valid) begin
         hist_q  <= hist_nxt;
         phase_q <= (!locked && tog_found) ? adv_hit : adv_cur;
      end
   end

   lock_ctrl #(.LOCK_WORDS(LOCK_WORDS), .LOSS_WORDS(LOSS_WORDS)) u_lock (
      .clk      (clk),
      .srst_i   (srst),
      .active_i (active),
      .valid_i  (rx_valid),
      .clean_i  (clean),
      .bad_i    (bad),
      .lock_o   (locked)
   );

   assign cnt_en = active && locked && rx_valid;

   ber_accum #(.CNT_W(CNT_W), .INC_W(POP_W)) u_bits (
      .clk    (clk),
      .srst_i (srst),
      .en_i   (cnt_en),
      .inc_i  (POP_W'(W)),
      .cnt_o  (bits_tested),
      .hit_o  (hit_b)
   );

   ber_accum #(.CNT_W(CNT_W), .INC_W(POP_W)) u_errs (
      .clk    (clk),
      .srst_i (srst),
      .en_i   (cnt_en),
      .inc_i  (pop),
      .cnt_o  (error_bits),
      .hit_o  (hit_e)
   );

   always_ff @(posedge clk) begin
      if (srst) count_saturated <= 1'b0;
      else      count_saturated <= count_saturated || hit_b || hit_e;
   end

   AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (srst)
      locked |-> run_q); // R2
   AST_BITS_STEP: assert property (@(posedge clk) disable iff (srst)
      cnt_en |=> (bits_tested == $past(bits_tested) + CNT_W'(W)) || (bits_tested == CMAX)); // R6
   AST_ERRS_WITHIN_BITS: assert property (@(posedge clk) disable iff (srst)
      error_bits <= bits_tested); // R7
   AST_SAT_STICKY: assert property (@(posedge clk) disable iff (srst)
      count_saturated |=> count_saturated); // R10
   AST_NO_LOCK_UNUSED: assert property (@(posedge clk) disable iff (srst)
      $rose(locked) |-> $past(is_prbs(pat_sel) || is_toggle(pat_sel))); // R12

endmodule

// File: tb/prbs_ber_monitor_tb.sv
module prbs_ber_monitor_tb;

   localparam int W    = 32;
   localparam int CW   = 14;
   localparam longint CMAX = (64'd1 << CW) - 1;

   logic          clk = 1'b0;
   logic          srst = 1'b1;
   logic          start = 1'b0;
   logic          stop = 1'b0;
   logic [2:0]    pat_sel = 3'd0;
   logic [W-1:0]  rx_data = '0;
   logic          rx_valid = 1'b0;
   logic          locked;
   logic [CW-1:0] bits_tested;
   logic [CW-1:0] error_bits;
   logic          count_saturated;

   prbs_ber_monitor #(.W(W), .CNT_W(CW)) u_dut (
      .clk(clk), .srst(srst), .start(start), .stop(stop), .pat_sel(pat_sel),
      .rx_data(rx_data), .rx_valid(rx_valid), .locked(locked),
      .bits_tested(bits_tested), .error_bits(error_bits),
      .count_saturated(count_saturated)
   );

   always #2 clk = ~clk;

   int     n_chk = 0;
   int     n_fail = 0;
   bit     done = 0;
   logic [30:0] bh;
   int     fpos;
   longint exp_bits, exp_err;
   bit     exp_sat, lock_seen, run_exp;

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int popc(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic longint sat_add(input longint a, input longint b);
      return (a + b >= CMAX) ? CMAX : a + b;
   endfunction

   function automatic int ltap(input logic [2:0] s);
      case (s) 3'd0: return 7; 3'd1: return 15; 3'd2: return 23; default: return 31; endcase
   endfunction

   function automatic int stap(input logic [2:0] s);
      case (s) 3'd0: return 6; 3'd1: return 14; 3'd2: return 18; default: return 28; endcase
   endfunction

   function automatic logic [W-1:0] rand_mask(input int n);
      logic [W-1:0] m = '0;
      while (popc(m) < n) m[$urandom_range(W-1, 0)] = 1'b1;
      return m;
   endfunction

   task automatic next_word(output logic [W-1:0] w);
      logic b;
      for (int i = 0; i < W; i++) begin
         if (pat_sel <= 3'd3) begin
            b  = bh[ltap(pat_sel)-1] ^ bh[stap(pat_sel)-1];
            bh = {bh[29:0], b};
         end else if (pat_sel == 3'd4) begin
            b = ((fpos % 2) == 0);
            fpos = (fpos + 1) % 10;
         end else if (pat_sel == 3'd5) begin
            b = ((fpos % 10) < 5);
            fpos = (fpos + 1) % 10;
         end else begin
            b = 1'($urandom_range(1, 0));
         end
         w[i] = b;
      end
   endtask

   task automatic chk_counts(input string tag);
      chk("R6", {tag, " bits_tested"}, longint'(bits_tested), exp_bits);
      chk("R7", {tag, " error_bits"}, longint'(error_bits), exp_err);
      chk("R10", {tag, " count_saturated"}, longint'(count_saturated), longint'(exp_sat));
   endtask

   task automatic send_raw(input logic [W-1:0] w, input int nerr, input bit with_stop);
      @(negedge clk);
      rx_data = w; rx_valid = 1'b1; stop = with_stop;
      @(posedge clk); #1;
      stop = 1'b0;
      if (lock_seen && run_exp && !with_stop) begin
         exp_bits = sat_add(exp_bits, W);
         exp_err  = sat_add(exp_err, nerr);
         if (exp_bits == CMAX || exp_err == CMAX) exp_sat = 1;
      end
      if (with_stop) run_exp = 0;
      lock_seen = locked;
   endtask

   task automatic send_pat(input logic [W-1:0] mask, input string tag);
      logic [W-1:0] w;
      next_word(w);
      send_raw(w ^ mask, popc(mask), 0);
      chk_counts(tag);
   endtask

   task automatic send_clean(input int n, input string tag);
      for (int k = 0; k < n; k++) send_pat('0, tag);
   endtask

   task automatic idle(input int n);
      @(negedge clk); rx_valid = 1'b0;
      repeat (n) begin
         rx_data = W'($urandom);
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input logic [2:0] sel);
      @(negedge clk); srst = 1'b1; rx_valid = 1'b0; pat_sel = sel;
      @(negedge clk); @(negedge clk); srst = 1'b0;
      exp_bits = 0; exp_err = 0; exp_sat = 0; lock_seen = 0; run_exp = 0;
      bh = 31'($urandom) | 31'h1;
      fpos = $urandom_range(9, 0);
   endtask

   task automatic start_run();
      @(negedge clk); start = 1'b1; rx_valid = 1'b0;
      @(negedge clk); start = 1'b0;
      run_exp = 1;
   endtask

   initial begin
      void'($urandom(32'd2718));
      // R1: reset state
      do_reset(3'd3);
      #1;
      chk("R1", "locked after reset", longint'(locked), 0);
      chk("R1", "bits after reset", longint'(bits_tested), 0);
      chk("R1", "errors after reset", longint'(error_bits), 0);
      chk("R1", "sat after reset", longint'(count_saturated), 0);

      // R4: all-zero words under PRBS31 never lock
      start_run();
      for (int k = 0; k < 40; k++) send_raw('0, 0, 0);
      chk("R4", "locked on zero words", longint'(locked), 0);
      chk_counts("R4 zeros");

      // R3, R6, R7: each PRBS polynomial from a random seed
      for (int p = 0; p < 4; p++) begin
         do_reset(3'(p));
         start_run();
         send_clean(31, "R3 search");
         chk("R3", "locked before 32 words", longint'(locked), 0);
         send_clean(2, "R3 search");
         chk("R3", "locked after 33 words", longint'(locked), 1);
         for (int k = 0; k < 20; k++)
            send_pat(($urandom_range(2, 0) == 0) ? rand_mask($urandom_range(8, 1)) : '0, "R7 errors");
         chk("R7", "lock kept with sparse errors", longint'(locked), 1);
         // R6: cycles without rx_valid do not count
         idle(5);
         chk_counts("R6 idle");
      end

      // R8: loss threshold, R9: relock, PRBS23
      do_reset(3'd2);
      start_run();
      send_clean(33, "R8 setup");
      for (int k = 0; k < 3; k++) send_pat('1, "R8 three bad");
      chk("R8", "lock after three bad words", longint'(locked), 1);
      send_clean(1, "R8 good");
      for (int k = 0; k < 3; k++) send_pat('1, "R8 four bad");
      chk("R8", "lock after three of four bad", longint'(locked), 1);
      send_pat('1, "R8 fourth bad");
      chk("R8", "lock after fourth bad word", longint'(locked), 0);
      send_clean(31, "R9 reload");
      chk("R9", "relocked too early", longint'(locked), 0);
      send_clean(1, "R9 reload");
      chk("R9", "relock after 32 words", longint'(locked), 1);

      // R2, R11, R3 exact: stop with a word, hold, restart
      begin
         logic [W-1:0] w;
         next_word(w);
         send_raw(w ^ rand_mask(3), 3, 1);
         chk("R2", "locked after stop", longint'(locked), 0);
         chk_counts("R2 stop word");
      end
      send_clean(5, "R11 stopped");
      chk("R11", "locked while stopped", longint'(locked), 0);
      start_run();
      chk_counts("R11 restart");
      send_clean(31, "R3 exact");
      chk("R3", "locked at 31 words", longint'(locked), 0);
      send_clean(1, "R3 exact");
      chk("R3", "locked at 32 words", longint'(locked), 1);
      send_clean(3, "R6 after restart");

      // R5: toggle patterns at random rotation
      for (int p = 4; p < 6; p++) begin
         do_reset(3'(p));
         start_run();
         send_clean(31, "R5 search");
         chk("R5", "toggle locked early", longint'(locked), 0);
         send_clean(1, "R5 search");
         chk("R5", "toggle locked at 32", longint'(locked), 1);
         for (int k = 0; k < 12; k++)
            send_pat(($urandom_range(1, 0) == 0) ? rand_mask($urandom_range(6, 1)) : '0, "R5 errors");
         chk("R5", "toggle lock kept", longint'(locked), 1);
      end

      // R12: unused selector codes
      for (int p = 6; p < 8; p++) begin
         do_reset(3'(p));
         start_run();
         send_clean(40, "R12 unused");
         chk("R12", "locked on unused code", longint'(locked), 0);
      end

      // R10: saturation with PRBS7
      do_reset(3'd0);
      start_run();
      send_clean(33, "R10 setup");
      for (int k = 0; k < 530; k++)
         send_pat(($urandom_range(3, 0) == 0) ? rand_mask($urandom_range(4, 1)) : '0, "R10 fill");
      chk("R10", "bits at ceiling", longint'(bits_tested), CMAX);
      chk("R10", "sticky flag", longint'(count_saturated), 1);

      // R1: reset clears everything after use
      do_reset(3'd0);
      #1;
      chk("R1", "bits after second reset", longint'(bits_tested), 0);
      chk("R1", "errors after second reset", longint'(error_bits), 0);
      chk("R1", "sat after second reset", longint'(count_saturated), 0);
      chk("R1", "lock after second reset", longint'(locked), 0);
      finish_run();
   end

endmodule